// File: doc/BRIEF.md
# MII Nibble Manchester Transmitter

This block is the 10 Mb/s transmit data path between an MII MAC and a serial line-code output. It runs from a 20 MHz clock, which is the half-bit symbol rate. It divides that clock by eight to make the 2.5 MHz MII transmit clock it hands back to the MAC. Each rising edge of that transmit clock is a capture point. At a capture point, if transmit-enable is high, the 4-bit nibble is loaded and sent over the next eight clock cycles. The nibble goes out as four bits, least significant bit first. Each bit is two Manchester half-bit symbols on a single-bit line output.

A small controller with two states decides what the serialiser does on every clock edge.
- In `ST_IDLE` the line holds the idle level.
  - A capture with transmit-enable high takes the load transition to `ST_SEND`.
  - A capture with transmit-enable low keeps the block in `ST_IDLE`.
- In `ST_SEND` the serialiser alternates between emitting the second half of the current bit and shifting to the next bit.
  - A capture with transmit-enable high reloads the serialiser and stays in `ST_SEND`, so nibbles follow each other with no gap.
  - A capture with transmit-enable low takes the stop transition back to `ST_IDLE`.

The synchronous reset returns the controller to `ST_IDLE`.

Top module: `mii_manchester_tx`

## Requirements
- R1: `tx_clk` is `clk` divided by 8 with equal high and low time. After reset is released, it is low for the first 4 cycles. It rises at the 4th rising `clk` edge after release, and every 8 edges after that.
- R2: `txd` and `tx_en` are sampled only at the `clk` edge where `tx_clk` rises. Their values at all other edges have no effect on `line_out`.
- R3: When `tx_en` is 1 at a capture edge, the first symbol of that nibble appears on `line_out` right after that same edge. Bits go out least significant bit first. Each bit lasts 2 `clk` cycles, so a nibble lasts 8 cycles and ends at the next capture edge.
- R4: Manchester coding: a 1 bit is sent as 0 for the first half and 1 for the second half. A 0 bit is sent as 1 then 0.
- R5: Nibbles captured at consecutive capture edges are sent back to back, with no idle symbol between them.
- R6: When `tx_en` is 0 at a capture edge, `line_out` goes to the idle level 0 right after that edge. It stays there until a later capture with `tx_en` at 1.
- R7: While `rst` is high at a `clk` edge, `tx_clk` and `line_out` are 0 after that edge, and `txd` and `tx_en` are ignored.
- R8: Asserting reset in the middle of a nibble drops the rest of its symbols. After release, the divider restarts from its first phase and nothing is sent until a new capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 20 MHz half-bit symbol clock |
| rst | input | 1 | Synchronous active-high reset |
| txd | input | 4 | Transmit nibble from the MAC |
| tx_en | input | 1 | Transmit enable; marks the nibble as valid |
| tx_clk | output | 1 | 2.5 MHz MII transmit clock (clk / 8) |
| line_out | output | 1 | Manchester-coded serial symbol stream |

## Verification
Every ordered pair of nibble values is sent as a two-nibble frame followed by one idle period. Comparing each pair tells apart bit order, coding polarity and any carry-over between adjacent nibbles. In those frames, `txd` and `tx_en` carry pseudo-random junk on every edge except the capture edge, which separates correct sampling from sampling at the wrong phase. A sixteen-nibble frame shows whether long runs stay gap-free. A reset asserted in the middle of a nibble, with `tx_en` held high, shows whether the abort and the restart of the divider phase work.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

    // Controller states
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_e;

    // Per-edge action requested from the serialiser
    typedef enum logic [1:0] {
        ACT_IDLE   = 2'd0,   // drive idle level
        ACT_LOAD   = 2'd1,   // load a new nibble, emit first half of its bit 0
        ACT_SECOND = 2'd2,   // emit second half of the current bit
        ACT_SHIFT  = 2'd3    // advance to next bit, emit its first half
    } sym_act_e;

endpackage

// File: rtl/mtx_clkgen.sv
module mtx_clkgen #(
    parameter int DIV = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    output logic [$clog2(DIV)-1:0]     ph,
    output logic                       cap_stb,
    output logic                       sym_second,
    output logic                       tx_clk
);
    localparam int PW   = $clog2(DIV);
    localparam int HALF = DIV / 2;
    localparam int CAP  = HALF - 1;
    localparam bit CAP_ODD = (CAP % 2) == 1;

    logic [PW-1:0] ph_nxt;

    always_comb begin
        if (ph == PW'(DIV - 1)) ph_nxt = '0;
        else                    ph_nxt = ph + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= '0;
            tx_clk <= 1'b0;
        end else begin
            ph     <= ph_nxt;
            tx_clk <= (ph_nxt >= PW'(HALF));
        end
    end

    // The edge leaving phase CAP is the rising edge of tx_clk.
    assign cap_stb    = (ph == PW'(CAP));
    // The symbol produced at this edge is a second half when (ph - CAP) is odd.
    assign sym_second = ph[0] ^ CAP_ODD;

endmodule

// File: rtl/mtx_ctrl.sv
module mtx_ctrl
    import mtx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cap_stb,
    input  logic     tx_en,
    input  logic     sym_second,
    output logic     st_send,
    output sym_act_e act
);
    tx_state_e st, st_nxt;

    // State register
    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nxt;
    end

    // Next state and outputs
    always_comb begin
        st_nxt = st;
        act    = ACT_IDLE;
        unique case (st)
            ST_IDLE: begin
                if (cap_stb && tx_en) begin
                    st_nxt = ST_SEND;       // load transition
                    act    = ACT_LOAD;
                end
            end
            ST_SEND: begin
                if (cap_stb) begin
                    if (tx_en) begin
                        act = ACT_LOAD;     // reload, stay in SEND
                    end else begin
                        st_nxt = ST_IDLE;   // stop transition
                        act    = ACT_IDLE;
                    end
                end else if (sym_second) begin
                    act = ACT_SECOND;
                end else begin
                    act = ACT_SHIFT;
                end
            end
            default: begin
                st_nxt = ST_IDLE;
                act    = ACT_IDLE;
            end
        endcase
    end

    assign st_send = (st == ST_SEND);

endmodule

// File: rtl/mtx_serdes.sv
module mtx_serdes
    import mtx_pkg::*;
#(
    parameter int   NIB_W    = 4,
    parameter logic IDLE_LVL = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  sym_act_e         act,
    input  logic [NIB_W-1:0] txd,
    output logic             line_out
);
    logic [NIB_W-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg     <= '0;
            line_out <= IDLE_LVL;
        end else begin
            unique case (act)
                ACT_LOAD: begin
                    sreg     <= txd;
                    line_out <= ~txd[0];
                end
                ACT_SECOND: begin
                    line_out <= sreg[0];
                end
                ACT_SHIFT: begin
                    sreg     <= sreg >> 1;
                    line_out <= ~sreg[1];
                end
                default: begin
                    line_out <= IDLE_LVL;
                end
            endcase
        end
    end

endmodule

// File: rtl/mii_manchester_tx.sv
module mii_manchester_tx
    import mtx_pkg::*;
#(
    parameter int   NIB_W    = 4,
    parameter logic IDLE_LVL = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NIB_W-1:0] txd,
    input  logic             tx_en,
    output logic             tx_clk,
    output logic             line_out
);
    localparam int DIV = 2 * NIB_W;
    localparam int PW  = $clog2(DIV);

    logic [PW-1:0] ph;
    logic          cap_stb;
    logic          sym_second;
    logic          st_send;
    sym_act_e      act;

    mtx_clkgen #(.DIV(DIV)) u_clkgen (
        .clk        (clk),
        .rst        (rst),
        .ph         (ph),
        .cap_stb    (cap_stb),
        .sym_second (sym_second),
        .tx_clk     (tx_clk)
    );

    mtx_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cap_stb    (cap_stb),
        .tx_en      (tx_en),
        .sym_second (sym_second),
        .st_send    (st_send),
        .act        (act)
    );

    mtx_serdes #(.NIB_W(NIB_W), .IDLE_LVL(IDLE_LVL)) u_serdes (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .txd      (txd),
        .line_out (line_out)
    );

endmodule

// File: rtl/mtx_checker.sv
module mtx_checker #(
    parameter int   PW       = 3,
    parameter int   DIV      = 8,
    parameter logic IDLE_LVL = 1'b0
) (
    input logic          clk,
    input logic          rst,
    input logic          tx_clk,
    input logic          line_out,
    input logic          txd_lsb,
    input logic          tx_en,
    input logic [PW-1:0] ph,
    input logic          cap_stb,
    input logic          st_send
);
    // R1: tx_clk rises leaving the capture phase, falls leaving the last phase
    p_txclk_rise_r1: assert property (@(posedge clk) disable iff (rst)
        cap_stb |=> $rose(tx_clk));
    p_txclk_fall_r1: assert property (@(posedge clk) disable iff (rst)
        (ph == PW'(DIV - 1)) |=> $fell(tx_clk));

    // R2: the controller state only moves at capture edges
    p_steady_r2: assert property (@(posedge clk) disable iff (rst)
        !cap_stb |=> $stable(st_send));

    // R3: a captured nibble starts with the first half of its bit 0
    p_load_r3: assert property (@(posedge clk) disable iff (rst)
        (cap_stb && tx_en) |=> (st_send && (line_out == ~$past(txd_lsb))));

    // R4: the second half-symbol of every bit is the complement of the first
    p_pair_r4: assert property (@(posedge clk) disable iff (rst)
        (st_send && ph[0]) |-> (line_out != $past(line_out)));

    // R6: stop at a capture with enable low, and idle level while stopped
    p_stop_r6: assert property (@(posedge clk) disable iff (rst)
        (cap_stb && !tx_en) |=> !st_send);
    p_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !st_send |-> (line_out == IDLE_LVL));

    // R7: reset forces both outputs low
    p_reset_r7: assert property (@(posedge clk)
        rst |=> (!tx_clk && (line_out == IDLE_LVL)));

endmodule

bind mii_manchester_tx mtx_checker #(.PW(PW), .DIV(DIV), .IDLE_LVL(IDLE_LVL)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tx_clk   (tx_clk),
    .line_out (line_out),
    .txd_lsb  (txd[0]),
    .tx_en    (tx_en),
    .ph       (ph),
    .cap_stb  (cap_stb),
    .st_send  (st_send)
);

// File: tb/tb_mii_manchester_tx.sv
`timescale 1ns/1ps
module tb_mii_manchester_tx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] txd = 4'd0;
    logic       tx_en = 1'b0;
    wire        tx_clk;
    wire        line_out;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    bit    chk_on = 0;
    string phase_tag = "R7";
    logic [7:0] lf = 8'h5A;

    // Reference model, from the requirements
    int         m_ph   = 0;
    logic       m_clk  = 1'b0;
    logic       m_line = 1'b0;
    logic       m_act  = 1'b0;
    logic [3:0] m_nib  = 4'd0;
    int         m_sym  = 0;   // symbol index of the current cycle, -1 when idle

    mii_manchester_tx dut (
        .clk      (clk),
        .rst      (rst),
        .txd      (txd),
        .tx_en    (tx_en),
        .tx_clk   (tx_clk),
        .line_out (line_out)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        int s;
        chk_on <= 1'b1;
        if (rst) begin
            m_ph <= 0; m_clk <= 1'b0; m_line <= 1'b0; m_act <= 1'b0; m_sym <= -1;
        end else begin
            s = (m_ph - 3 + 8) % 8;
            m_ph  <= (m_ph + 1) % 8;
            m_clk <= (((m_ph + 1) % 8) >= 4);
            if (m_ph == 3) begin
                if (tx_en) begin
                    m_nib <= txd; m_act <= 1'b1; m_line <= ~txd[0]; m_sym <= 0;
                end else begin
                    m_act <= 1'b0; m_line <= 1'b0; m_sym <= -1;
                end
            end else if (m_act) begin
                m_line <= (s % 2 == 1) ? m_nib[s/2] : ~m_nib[s/2];
                m_sym  <= s;
            end
        end
    end

    always @(negedge clk) begin
        string lt;
        if (chk_on && !done) begin
            checks++;
            if (tx_clk !== m_clk) begin
                fails++;
                $display("FAIL %s/R1 tx_clk got %b exp %b at %0t", phase_tag, tx_clk, m_clk, $time);
            end
            if (rst)             lt = "R7";
            else if (!m_act)     lt = "R6";
            else if (m_sym == 0) lt = "R3";
            else                 lt = "R4";
            checks++;
            if (line_out !== m_line) begin
                fails++;
                $display("FAIL %s/%s line_out got %b exp %b at %0t", phase_tag, lt, line_out, m_line, $time);
            end
        end
    end

    // One transmit-clock period: junk on non-capture edges, the real value on the capture edge
    task automatic slot(input bit en, input logic [3:0] v, input bit junk);
        bit fin = 0;
        while (!fin) begin
            @(negedge clk);
            if (m_ph == 3) begin
                txd = v; tx_en = en; fin = 1;
            end else if (junk) begin
                lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
                txd = lf[3:0]; tx_en = lf[4];
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R7: reset state, inputs active but ignored
        tx_en = 1'b1; txd = 4'hF;
        repeat (5) @(negedge clk);
        tx_en = 1'b0;
        rst = 1'b0;

        // R2/R3/R4: every ordered nibble pair, junk between capture edges
        phase_tag = "R2";
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                slot(1'b1, 4'(a), 1'b0);
                slot(1'b1, 4'(b), 1'b1);
                slot(1'b0, 4'h0, 1'b1);
            end
        end

        // R5: long back-to-back frame
        phase_tag = "R5";
        for (int i = 0; i < 16; i++) slot(1'b1, 4'(15 - i), 1'b1);
        slot(1'b0, 4'h0, 1'b0);
        slot(1'b0, 4'h0, 1'b1);

        // R8: reset in the middle of a nibble with enable held high
        phase_tag = "R8";
        slot(1'b1, 4'hA, 1'b0);
        repeat (3) @(negedge clk);
        txd = 4'h3; tx_en = 1'b1;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tx_en = 1'b0;
        slot(1'b1, 4'h6, 1'b0);
        slot(1'b1, 4'h9, 1'b0);
        slot(1'b0, 4'h0, 1'b0);
        slot(1'b0, 4'h0, 1'b0);

        repeat (4) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule